// File: doc/BRIEF.md
# Reference-Windowed Clock Frequency Counter

This block measures how fast one chosen on-chip clock runs. Software picks a source through a group select and a sub-select, loads a window length counted in reference ticks, and starts a run. The measured clock's edges are counted for the length of that window. When the window has closed and the measured side has stopped counting, a done flag rises, and the edge count can be read. Software turns the count into a frequency.

Each run follows a fixed handshake. Software writes the control word with the run bit clear, which stops the run and loads the window. It waits for the done flag to read low. It then writes the same window with the run bit set, polls for done, and writes a stop. The edge counter sits in the measured clock's own domain and is cleared only by that clock. A source that is not toggling therefore reports the count left over from the previous run. Comparing a short run against a long run exposes such a dead clock.

Top module: `clkmeter_top`

## Requirements
- R1: After reset, `status` is all zeros and no run is active.
- R2: Writing address 0 with bit 20 clear stops any run, loads the window from bits WIN_W-1:0, and drives the done bit (`status` bit CNT_W) low two clocks later. The count field is left unchanged.
- R3: Writing address 0 with bit 20 set starts a run. The reference counter steps down once per `ref_tick` pulse, so the window lasts the loaded number of ticks (about 4 clocks each with the bench's tick rate).
- R4: The done bit stays low while the window is open. It rises only after the window has expired and the measured domain has dropped its enable, and it stays high until the next stop write.
- R5: When done is high, `status` bits CNT_W-1:0 hold the number of measured-clock edges seen during the window. This matches window time divided by source period, within one reference tick's worth of edges plus 5.
- R6: Address 1 bit 0 selects the group (0 = low-speed sources 0..N-1, 1 = high-speed sources N..2N-1). Address 2 bit 0 enables the source. Address 2 bits 6:1 are the code inside the group. The measured source index is group*N + code, where N = SRC_PER_GRP.
- R7: The edge count stops at all ones (4095 for CNT_W=12) instead of wrapping.
- R8: If the selected source is stopped, disabled (enable bit 0) or has a code of N or more, done still rises and the count equals the previous run's count exactly.
- R9: Writes to addresses 1 and 2 while a run is active are ignored. The current run and later runs keep the source chosen before the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and reference clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle reference tick enable |
| src_clk | input | 2*SRC_PER_GRP | Candidate clocks to measure |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 control, 1 group, 2 sub-select) |
| wr_data | input | 32 | Register write data |
| status | output | CNT_W+1 | Done flag in bit CNT_W, edge count below |

## Verification
The hardest situation to reach is the stale-count case. It needs a source that never toggles while a run starts and ends, so that the edge counter cannot clear, and the bench must know the exact value that should survive. The stimulus first makes a normal run on a live clock and records the count. It then points the mux at a tied-off source, at a disabled selection and at an out-of-range code, and expects that same number each time. Saturation is reached by running a fast source over a long window with a narrowed counter. Select writes are also issued in the middle of an open window to show they are ignored.

// File: rtl/clkmeter_pkg.sv
package clkmeter_pkg;
  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_GRP  = 2'd1,
    ADDR_SUB  = 2'd2
  } reg_addr_e;

  localparam int RUN_BIT    = 20;
  localparam int SUB_CODE_W = 6;
  localparam int SUB_LSB    = 1;
endpackage

// File: rtl/clkmeter_sync.sv
module clkmeter_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/clkmeter_refwin.sv
module clkmeter_refwin
  import clkmeter_pkg::*;
#(
  parameter int WIN_W = 20
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ref_tick,
  input  logic                  wr_en,
  input  logic [1:0]            wr_addr,
  input  logic [31:0]           wr_data,
  input  logic                  meas_busy,
  output logic                  run_req,
  output logic                  done,
  output logic                  grp_hi,
  output logic                  sub_en,
  output logic [SUB_CODE_W-1:0] sub_code
);
  logic             running_q;
  logic [WIN_W-1:0] win_q;
  logic             run_req_q;
  logic             done_q;
  logic             grp_q;
  logic             sub_en_q;
  logic [SUB_CODE_W-1:0] sub_code_q;
  logic             ctrl_wr;
  logic             expired;

  assign ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);
  assign expired = running_q && (win_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      running_q  <= 1'b0;
      win_q      <= '0;
      run_req_q  <= 1'b0;
      done_q     <= 1'b0;
      grp_q      <= 1'b0;
      sub_en_q   <= 1'b0;
      sub_code_q <= '0;
    end else begin
      if (ctrl_wr) begin
        win_q     <= wr_data[WIN_W-1:0];
        running_q <= wr_data[RUN_BIT];
      end else if (running_q && ref_tick && (win_q != '0)) begin
        win_q <= win_q - 1'b1;
      end
      run_req_q <= running_q && (win_q != '0);
      if (ctrl_wr) done_q <= 1'b0;
      else         done_q <= expired && !meas_busy;
      if (!running_q && wr_en && (wr_addr == ADDR_GRP)) grp_q <= wr_data[0];
      if (!running_q && wr_en && (wr_addr == ADDR_SUB)) begin
        sub_en_q   <= wr_data[0];
        sub_code_q <= wr_data[SUB_LSB +: SUB_CODE_W];
      end
    end
  end

  assign run_req  = run_req_q;
  assign done     = done_q;
  assign grp_hi   = grp_q;
  assign sub_en   = sub_en_q;
  assign sub_code = sub_code_q;

  a_r3_window_hold: assert property (@(posedge clk) disable iff (rst)
    (running_q && !ref_tick && !ctrl_wr) |=> $stable(win_q));

  a_r4_done_after_expiry: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (running_q && (win_q == '0)));

  a_r9_select_frozen: assert property (@(posedge clk) disable iff (rst)
    running_q |=> ($stable(grp_q) && $stable(sub_en_q) && $stable(sub_code_q)));
endmodule

// File: rtl/clkmeter_srcmux.sv
module clkmeter_srcmux
  import clkmeter_pkg::*;
#(
  parameter int SRC_PER_GRP = 4
) (
  input  logic [2*SRC_PER_GRP-1:0] src_clk,
  input  logic                     grp_hi,
  input  logic                     sub_en,
  input  logic [SUB_CODE_W-1:0]    sub_code,
  output logic                     meas_clk
);
  localparam int NSRC = 2 * SRC_PER_GRP;

  logic code_ok;
  int   pick;

  assign code_ok = sub_en && (int'(sub_code) < SRC_PER_GRP);
  assign pick    = (grp_hi ? SRC_PER_GRP : 0) + int'(sub_code);

  always_comb begin
    meas_clk = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (code_ok && (pick == i)) meas_clk = src_clk[i];
    end
  end
endmodule

// File: rtl/clkmeter_edgecnt.sv
module clkmeter_edgecnt #(
  parameter int CNT_W = 25
) (
  input  logic             mclk,
  input  logic             rst,
  input  logic             run_req,
  output logic             busy,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             en_m;
  logic             en_d;
  logic             start_edge;
  logic [CNT_W-1:0] cnt_q;

  clkmeter_sync #(.STAGES(2)) u_en_sync (
    .clk (mclk),
    .rst (rst),
    .d   (run_req),
    .q   (en_m)
  );

  assign start_edge = en_m && !en_d;

  always_ff @(posedge mclk) begin
    if (rst) begin
      en_d  <= 1'b0;
      cnt_q <= '0;
    end else begin
      en_d <= en_m;
      if (start_edge)                   cnt_q <= '0;
      else if (en_m && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign busy  = en_m;
  assign count = cnt_q;

  a_r7_saturate: assert property (@(posedge mclk) disable iff (rst)
    ((cnt_q == CNT_MAX) && !start_edge) |=> (cnt_q == CNT_MAX));

  a_r8_idle_holds: assert property (@(posedge mclk) disable iff (rst)
    (!en_m && !en_d) |=> $stable(cnt_q));
endmodule

// File: rtl/clkmeter_top.sv
module clkmeter_top
  import clkmeter_pkg::*;
#(
  parameter int SRC_PER_GRP = 4,
  parameter int WIN_W       = 20,
  parameter int CNT_W       = 25
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ref_tick,
  input  logic [2*SRC_PER_GRP-1:0] src_clk,
  input  logic                     wr_en,
  input  logic [1:0]               wr_addr,
  input  logic [31:0]              wr_data,
  output logic [CNT_W:0]           status
);
  logic                  run_req;
  logic                  done;
  logic                  grp_hi;
  logic                  sub_en;
  logic [SUB_CODE_W-1:0] sub_code;
  logic                  meas_clk;
  logic                  busy_m;
  logic                  busy_r;
  logic [CNT_W-1:0]      cnt_m;
  logic [CNT_W-1:0]      cap_q;
  logic [CNT_W-1:0]      cap_nxt;
  logic [CNT_W:0]        status_q;
  logic                  stop_wr;

  clkmeter_refwin #(.WIN_W(WIN_W)) u_refwin (
    .clk       (clk),
    .rst       (rst),
    .ref_tick  (ref_tick),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .meas_busy (busy_r),
    .run_req   (run_req),
    .done      (done),
    .grp_hi    (grp_hi),
    .sub_en    (sub_en),
    .sub_code  (sub_code)
  );

  clkmeter_srcmux #(.SRC_PER_GRP(SRC_PER_GRP)) u_srcmux (
    .src_clk  (src_clk),
    .grp_hi   (grp_hi),
    .sub_en   (sub_en),
    .sub_code (sub_code),
    .meas_clk (meas_clk)
  );

  clkmeter_edgecnt #(.CNT_W(CNT_W)) u_edgecnt (
    .mclk    (meas_clk),
    .rst     (rst),
    .run_req (run_req),
    .busy    (busy_m),
    .count   (cnt_m)
  );

  clkmeter_sync #(.STAGES(2)) u_busy_sync (
    .clk (clk),
    .rst (rst),
    .d   (busy_m),
    .q   (busy_r)
  );

  // The measured count is quiet once busy has come back low, so it is
  // sampled only while done is high.
  assign cap_nxt = done ? cnt_m : cap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q    <= '0;
      status_q <= '0;
    end else begin
      cap_q    <= cap_nxt;
      status_q <= {done, cap_nxt};
    end
  end

  assign status  = status_q;
  assign stop_wr = wr_en && (wr_addr == ADDR_CTRL) && !wr_data[RUN_BIT];

  a_r2_stop_drops_done: assert property (@(posedge clk) disable iff (rst)
    stop_wr |=> ##1 !status_q[CNT_W]);

  a_r5_count_frozen: assert property (@(posedge clk) disable iff (rst)
    (status_q[CNT_W] && $past(status_q[CNT_W])) |-> $stable(status_q[CNT_W-1:0]));
endmodule

// File: tb/test_clkmeter_top.sv
`timescale 1ns/1ps
module test_clkmeter_top;
  localparam int N  = 4;
  localparam int CW = 12;

  typedef struct {
    int    lo;
    int    hi;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_tick = 1'b0;
  logic [1:0] div = '0;
  logic s0 = 1'b0, s1 = 1'b0, s3 = 1'b0, s4 = 1'b0, s5 = 1'b0, s6 = 1'b0, s7 = 1'b0;
  logic s2;
  logic [2*N-1:0] src_clk;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [CW:0] status;

  int errors = 0, checks = 0;
  int cyc = 0;
  int mon_cnt = 0;
  int last_count = 0;
  int done_cyc = 0;
  logic prev_dn = 1'b0;
  exp_t q[$];

  always #10 clk = ~clk;
  always #20 s0 = ~s0;
  always #50 s1 = ~s1;
  assign s2 = 1'b0;
  always #15 s3 = ~s3;
  always #4  s4 = ~s4;
  always #5  s5 = ~s5;
  always #6  s6 = ~s6;
  always #7  s7 = ~s7;
  assign src_clk = {s7, s6, s5, s4, s3, s2, s1, s0};

  always @(negedge clk) begin
    div      <= div + 2'd1;
    ref_tick <= (div == 2'd2);
  end
  always @(posedge clk) cyc <= cyc + 1;

  clkmeter_top #(.SRC_PER_GRP(N), .WIN_W(20), .CNT_W(CW)) i_clkmeter_top (
    .clk      (clk),
    .rst      (rst),
    .ref_tick (ref_tick),
    .src_clk  (src_clk),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .status   (status)
  );

  task automatic check(input bit ok, input string tag, input int got, input int lo, input int hi);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d..%0d", tag, got, lo, hi);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pick(input bit g, input bit en, input int code);
    wr(2'd1, {31'd0, g});
    wr(2'd2, {25'd0, code[5:0], en});
  endtask

  // mid: 0 plain, 1 check done low in window (R4), 2 also write select (R9)
  task automatic run(input int w, input int lo, input int hi, input string tag, input int mid, input bit chk_len);
    exp_t e;
    int n, t0;
    e.lo = lo; e.hi = hi; e.tag = tag;
    q.push_back(e);
    wr(2'd0, 32'd0);
    wr(2'd0, w);
    while (status[CW]) @(negedge clk);
    n = mon_cnt;
    wr(2'd0, (32'd1 << 20) | w);
    t0 = cyc;
    if (mid != 0) begin
      repeat (100) @(negedge clk);
      check(status[CW] == 1'b0, "R4 done low inside window", int'(status[CW]), 0, 0);
      if (mid == 2) pick(1'b1, 1'b1, 1);
    end
    while (mon_cnt == n) @(negedge clk);
    if (chk_len)
      check((done_cyc - t0) >= w*4 - 8 && (done_cyc - t0) <= w*4 + 30,
            "R3 window length", done_cyc - t0, w*4 - 8, w*4 + 30);
    wr(2'd0, 32'd0);
  endtask

  function automatic int tol(input int p);
    return 80 / p + 5;
  endfunction

  task automatic live(input bit g, input int code, input int p, input int w, input string tag);
    int ex;
    ex = (w * 80) / p;
    pick(g, 1'b1, code);
    run(w, ex - tol(p), ex + tol(p), tag, 0, 1'b0);
  endtask

  // monitor: pops the expected item when done rises
  initial begin
    exp_t e;
    int got;
    forever begin
      @(negedge clk);
      if (status[CW] && !prev_dn) begin
        got = int'(status[CW-1:0]);
        if (q.size() == 0) begin
          check(1'b0, "R4 done without a run", got, 0, 0);
        end else begin
          e = q.pop_front();
          check(got >= e.lo && got <= e.hi, e.tag, got, e.lo, e.hi);
        end
        last_count = got;
        done_cyc = cyc;
        mon_cnt++;
      end
      prev_dn = status[CW];
    end
  end

  initial begin
    repeat (2000000 / 10) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int held;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(status == '0, "R1 reset status", int'(status), 0, 0);

    // R6/R5: low group source 0 (40 ns), with R3/R4 timing checks
    pick(1'b0, 1'b1, 0);
    run(200, 400 - tol(40), 400 + tol(40), "R5 R6 src0 count", 1, 1'b1);
    held = last_count;
    repeat (3) @(negedge clk);
    check(status[CW] == 1'b0, "R2 stop clears done", int'(status[CW]), 0, 0);
    check(int'(status[CW-1:0]) == held, "R2 count kept", int'(status[CW-1:0]), held, held);

    live(1'b0, 1, 100, 200, "R6 low group src1");
    live(1'b1, 1, 10, 200, "R6 high group src5");
    live(1'b1, 3, 14, 200, "R6 high group src7");
    live(1'b0, 3, 30, 200, "R5 low group src3");

    // R7: 8 ns source over 500 ticks would reach 5000
    pick(1'b1, 1'b1, 0);
    run(500, 4095, 4095, "R7 saturation", 0, 1'b0);

    live(1'b0, 3, 30, 200, "R5 clear after saturation");

    // R8: stopped, disabled and out-of-range sources keep the old count
    held = last_count;
    pick(1'b0, 1'b1, 2);
    run(50, held, held, "R8 stopped source", 0, 1'b0);
    pick(1'b0, 1'b0, 0);
    run(50, held, held, "R8 disabled source", 0, 1'b0);
    pick(1'b1, 1'b1, 5);
    run(50, held, held, "R8 code out of range", 0, 1'b0);

    // R9: select write during the run is ignored now and later
    pick(1'b0, 1'b1, 0);
    run(200, 400 - tol(40), 400 + tol(40), "R9 select ignored in run", 2, 1'b0);
    run(200, 400 - tol(40), 400 + tol(40), "R9 select still src0", 0, 1'b0);

    repeat (5) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule